// File: doc/BRIEF.md
# HDLC Gapped-Clock Byte Serializer

This block is the transmit end of a bit-oriented link. It takes bytes from an external FIFO or RAM over a parallel port and sends them one bit per bit clock on a serial line. It paces the FIFO with a gapped byte clock. Each rising edge of that clock asks for the next byte and its qualifiers, and the block captures them when the byte clock falls. Between frames it sends 0x7E flags without a break. While the send-message qualifier is high, each byte it captures is sent as message data. When that qualifier drops, the block closes the frame: it sends a CRC-16 frame check sequence if the FCS qualifier is high, and then a closing flag.

The line carries zero-bit transparency. The block inserts a zero after every run of five ones in message and FCS bits. A separate strobe marks overhead bit slots, which belong to a framer further down the line. Each stuffed zero and each overhead slot pushes back the payload by one bit clock and stretches the current byte-clock period by one cycle. In bypass mode the block is a plain byte serializer: it does no stuffing and sends no flags or FCS. An external frame-sync pulse sets where each byte starts.

Top module: `hdlc_gap_tx`

## Requirements
- R1: After reset the block sends 0x7E flags, least significant bit first (line bits 0,1,1,1,1,1,1,0). The byte clock is high in the first cycle after reset.
- R2: In a byte interval with no stuffed zero and no overhead slot, the byte clock has a period of exactly 8 bit clocks. It keeps running while idle flags are sent.
- R3: The byte clock is high for exactly the first 2 bit clocks of every byte interval.
- R4: After five consecutive ones in message or FCS bits, a zero is inserted. The run count carries across byte boundaries, and this holds even when a flag comes next. Flag bits are never stuffed, and each inserted zero lengthens its byte interval by one bit clock.
- R5: A bit clock with the overhead strobe high drives 0 on the line and does not advance the payload or the ones-run count. It lengthens its byte interval by one bit clock.
- R6: An interval with two stuffed zeros and one overhead slot lasts 11 bit clocks.
- R7: Data and qualifiers are sampled at the clock edge that ends the second high cycle of the byte clock. A byte presented at one rising edge is sent in the following interval, and changes to the inputs after that sampling edge have no effect.
- R8: While send-message is high, the captured bytes are sent as the frame body. When it falls with the FCS qualifier high, the block sends the ones-complement CRC-16 (polynomial x^16+x^12+x^5+1, preset 0xFFFF, data taken LSB first), low byte first. A closing flag follows. For bytes 0x31..0x39 the FCS bytes are 0x6E then 0x90.
- R9: When send-message falls with the FCS qualifier low, only a closing flag follows the last data byte.
- R10: In bypass mode every interval sends the most recently captured byte unchanged, LSB first, with no stuffing. The qualifiers are ignored, and no flag or FCS byte is sent.
- R11: In bypass mode a frame-sync pulse ends the current interval at that clock edge. The next cycle starts a new interval, with the byte clock high, and sends bit 0 of the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Byte to send |
| msg_i | input | 1 | Send-message qualifier (byte is frame data) |
| fcs_en_i | input | 1 | Append FCS when the message ends |
| ovh_i | input | 1 | Overhead slot strobe for this bit clock |
| bypass_i | input | 1 | Raw byte mode: no stuffing, flags or FCS |
| fsync_i | input | 1 | Byte-alignment pulse, used in bypass mode |
| ser_o | output | 1 | Serial line bit |
| bclk_o | output | 1 | Gapped byte-request clock |

## Verification
The bench decodes the line on its own: it removes stuffed zeros, finds flags and compares each frame against the bytes it supplied. It also measures every byte-clock period against 8 plus the stuffed zeros and overhead slots it saw in that interval. All-ones frames chase the stuffing carry across byte boundaries and into the closing flag, and data bytes equal to 0x7E must not be taken for flags. A design that reset its run count at each byte, or skipped stuffing before a flag, would produce a false flag or an abort, and the decoder would reject the frame. Dense all-ones data under periodic overhead slots must produce an 11-cycle interval. The bench also scrambles the byte just after the sampling edge, so a design that sampled late would send the wrong data. In bypass mode a run of 0xFF must come out as unbroken ones, and after a frame-sync pulse the interval must restart at once with bit 0 of the held byte.

// File: rtl/hdlc_gap_pkg.sv
`timescale 1ns/1ps
package hdlc_gap_pkg;
  localparam int          BYTE_W    = 8;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_POLY  = 16'h8408;  // x^16+x^12+x^5+1, reflected
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_FCS_HI, ST_FCS_END} seq_st_e;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = {1'b0, r[15:1]} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_gap_seq.sv
`timescale 1ns/1ps
module hdlc_gap_seq
  import hdlc_gap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              msg_i,
  input  logic              fcs_en_i,
  input  logic              cap_i,
  input  logic              load_i,
  output logic [BYTE_W-1:0] sym_o,
  output logic              stuff_o
);
  logic [BYTE_W-1:0] cap_byte_q;
  logic              cap_msg_q, cap_fcs_q;
  seq_st_e           st_q, st_n;
  logic [15:0]       crc_q, crc_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_byte_q <= '0;
      cap_msg_q  <= 1'b0;
      cap_fcs_q  <= 1'b0;
    end else if (cap_i) begin
      cap_byte_q <= byte_i;
      cap_msg_q  <= msg_i;
      cap_fcs_q  <= fcs_en_i;
    end
  end

  always_comb begin
    sym_o   = FLAG_BYTE;
    stuff_o = 1'b0;
    st_n    = ST_IDLE;
    crc_n   = crc_q;
    if (bypass_i) begin
      sym_o = cap_byte_q;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DATA: begin
          if (cap_msg_q) begin
            sym_o   = cap_byte_q;
            stuff_o = 1'b1;
            st_n    = ST_DATA;
            crc_n   = crc16_byte((st_q == ST_IDLE) ? CRC_SEED : crc_q, cap_byte_q);
          end else if (st_q == ST_DATA && cap_fcs_q) begin
            sym_o   = ~crc_q[7:0];
            stuff_o = 1'b1;
            st_n    = ST_FCS_HI;
          end
        end
        ST_FCS_HI: begin
          sym_o   = ~crc_q[15:8];
          stuff_o = 1'b1;
          st_n    = ST_FCS_END;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      crc_q <= CRC_SEED;
    end else if (load_i) begin
      st_q  <= st_n;
      crc_q <= crc_n;
    end
  end

  a_r9_flag_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !bypass_i && st_q == ST_DATA && !cap_msg_q && !cap_fcs_q) |=> st_q == ST_IDLE);
  a_r8_fcs_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !bypass_i && st_q == ST_FCS_HI) |=> st_q == ST_FCS_END);
  a_r10_bypass_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bypass_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/hdlc_gap_shift.sv
`timescale 1ns/1ps
module hdlc_gap_shift
  import hdlc_gap_pkg::*;
#(
  parameter int BW     = BYTE_W,
  parameter int RUN    = 5,
  parameter int HI_CYC = 2,
  parameter int CNT_W  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovh_i,
  input  logic          realign_i,
  input  logic [BW-1:0] sym_i,
  input  logic          stuff_i,
  output logic          load_o,
  output logic          cap_o,
  output logic          ser_o,
  output logic          bclk_o
);
  localparam int IDX_W  = $clog2(BW);
  localparam int ONES_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BW-1:0]     sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ONES_W-1:0] ones_q;
  logic              cnt_ones_q;
  logic              stuff_now, bit_go, cur_bit;

  // a pending stuff is owed to earlier bits, whatever symbol is loaded now
  assign stuff_now = (ones_q == ONES_W'(RUN));
  assign bit_go    = !ovh_i && !stuff_now;
  assign cur_bit   = sh_q[idx_q];
  assign load_o    = (bit_go && idx_q == IDX_W'(BW - 1)) || realign_i;
  assign cap_o     = (cnt_q == CNT_W'(HI_CYC - 1));
  assign bclk_o    = (cnt_q < CNT_W'(HI_CYC));
  assign ser_o     = bit_go & cur_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= BW'(FLAG_BYTE);
      cnt_ones_q <= 1'b0;
      idx_q      <= '0;
      cnt_q      <= '0;
      ones_q     <= '0;
    end else begin
      if (load_o) begin
        sh_q       <= sym_i;
        cnt_ones_q <= stuff_i;
        idx_q      <= '0;
        cnt_q      <= '0;
      end else begin
        if (bit_go) idx_q <= idx_q + IDX_W'(1);
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      end
      if (realign_i || (stuff_now && !ovh_i)) ones_q <= '0;
      else if (bit_go) ones_q <= (cnt_ones_q && cur_bit) ? ones_q + ONES_W'(1) : '0;
    end
  end

  a_r4_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= ONES_W'(RUN));
  a_r4_stuff_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_now && !ovh_i && !realign_i) |=> ones_q == '0);
  a_r5_ovh_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovh_i && !realign_i) |=> ($stable(idx_q) && $stable(ones_q)));
  a_r2_min_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !realign_i) |-> cnt_q >= CNT_W'(BW - 1));
  a_r7_cap_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> bclk_o);
  a_r3_fall_after_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !realign_i) |=> !bclk_o);
endmodule

// File: rtl/hdlc_gap_tx.sv
`timescale 1ns/1ps
module hdlc_gap_tx
  import hdlc_gap_pkg::*;
#(
  parameter int RUN    = 5,
  parameter int HI_CYC = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              msg_i,
  input  logic              fcs_en_i,
  input  logic              ovh_i,
  input  logic              bypass_i,
  input  logic              fsync_i,
  output logic              ser_o,
  output logic              bclk_o
);
  logic [BYTE_W-1:0] sym;
  logic              sym_stuff, load, cap, realign;

  assign realign = bypass_i & fsync_i;

  hdlc_gap_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .byte_i   (byte_i),
    .msg_i    (msg_i),
    .fcs_en_i (fcs_en_i),
    .cap_i    (cap),
    .load_i   (load),
    .sym_o    (sym),
    .stuff_o  (sym_stuff)
  );

  hdlc_gap_shift #(
    .BW     (BYTE_W),
    .RUN    (RUN),
    .HI_CYC (HI_CYC),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovh_i     (ovh_i),
    .realign_i (realign),
    .sym_i     (sym),
    .stuff_i   (sym_stuff),
    .load_o    (load),
    .cap_o     (cap),
    .ser_o     (ser_o),
    .bclk_o    (bclk_o)
  );
endmodule

// File: tb/hdlc_gap_tx_tb_top.sv
`timescale 1ns/1ps
module hdlc_gap_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       msg_i = 1'b0, fcs_en_i = 1'b0, ovh_i = 1'b0, bypass_i = 1'b0, fsync_i = 1'b0;
  logic       ser_o, bclk_o;

  always #4 clk = ~clk;

  hdlc_gap_tx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .byte_i(byte_i), .msg_i(msg_i), .fcs_en_i(fcs_en_i),
    .ovh_i(ovh_i), .bypass_i(bypass_i), .fsync_i(fsync_i), .ser_o(ser_o), .bclk_o(bclk_o)
  );

  // {first, step, len, fcs, ovh_period, known_fcs}
  localparam int NVEC = 8;
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h31, 8'h01, 8'd9,  8'd1, 8'd0,  16'h906E},
    {8'h00, 8'h11, 8'd6,  8'd1, 8'd0,  16'h0000},
    {8'hFF, 8'h00, 8'd5,  8'd1, 8'd0,  16'h0000},
    {8'h7E, 8'h00, 8'd4,  8'd1, 8'd0,  16'h0000},
    {8'hA5, 8'h3C, 8'd7,  8'd0, 8'd0,  16'h0000},
    {8'hF8, 8'h01, 8'd8,  8'd1, 8'd9,  16'h0000},
    {8'hFF, 8'h00, 8'd32, 8'd1, 8'd11, 16'h0000},
    {8'h00, 8'h00, 8'd1,  8'd0, 8'd5,  16'h0000}
  };

  int n_chk = 0, n_fail = 0;
  int ovh_per = 0, ocnt = 0;
  bit drv_prev = 1'b0, scramble = 1'b0, per_en = 1'b1, saw11 = 1'b0;
  logic [7:0] exp_b [0:63];
  int exp_n = 0, fr_cnt = 0;
  string cur_req = "R8";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int j = 0; j < n; j++)
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ exp_b[j][k]) c = (c >> 1) ^ 16'h8408;
        else c = c >> 1;
      end
    return ~c;
  endfunction

  // monitor: independent line decoder and byte-clock period meter
  bit mon_prev = 1'b0, mon_have = 1'b0;
  int per_cyc, per_hi, per_ovh, per_stuff;
  logic rxb [0:1023];
  int rxn = 0, rx_ones = 0;

  always @(negedge clk) begin
    bit is_stuff;
    string req;
    if (!rst_ni) begin
      mon_prev = 0; mon_have = 0; rxn = 0; rx_ones = 0;
      per_cyc = 0; per_hi = 0; per_ovh = 0; per_stuff = 0;
    end else begin
      is_stuff = 0;
      if (bclk_o && !mon_prev) begin
        if (mon_have && per_en) begin
          if (per_ovh != 0) req = "R5"; else if (per_stuff != 0) req = "R4"; else req = "R2";
          chk(per_cyc == 8 + per_ovh + per_stuff, req, "byte clock period", per_cyc, 8 + per_ovh + per_stuff);
          chk(per_hi == 2, "R3", "byte clock high cycles", per_hi, 2);
          if (per_cyc == 11 && per_stuff == 2 && per_ovh == 1) saw11 = 1;
        end
        mon_have = per_en;
        per_cyc = 0; per_hi = 0; per_ovh = 0; per_stuff = 0;
      end
      mon_prev = bclk_o;
      if (!ovh_i && !bypass_i) begin
        if (ser_o) begin
          rx_ones++;
          if (rxn < 1024) begin rxb[rxn] = 1'b1; rxn++; end
        end else if (rx_ones == 5) begin
          is_stuff = 1; rx_ones = 0;
        end else if (rx_ones == 6) begin
          rx_ones = 0;
          rxn = (rxn >= 7) ? rxn - 7 : 0;
          if (rxn > 0) begin
            int bad;
            fr_cnt++;
            chk(rxn == exp_n * 8, cur_req, "frame bit count", rxn, exp_n * 8);
            bad = 0;
            if (rxn == exp_n * 8)
              for (int j = 0; j < exp_n; j++)
                for (int k = 0; k < 8; k++)
                  if (rxb[8*j+k] !== exp_b[j][k]) bad++;
            chk(bad == 0, cur_req, "frame bit mismatches", bad, 0);
          end
          rxn = 0;
        end else begin
          rx_ones = 0;
          if (rxn < 1024) begin rxb[rxn] = 1'b0; rxn++; end
        end
      end
      per_cyc++;
      per_hi += int'(bclk_o);
      per_ovh += int'(ovh_i);
      per_stuff += int'(is_stuff);
    end
  end

  task automatic step_cycle(output bit rise);
    @(posedge clk); #1;
    rise = bclk_o && !drv_prev;
    drv_prev = bclk_o;
    if (ovh_per != 0) begin
      ocnt = (ocnt + 1) % ovh_per;
      ovh_i = (ocnt == 0);
    end else ovh_i = 1'b0;
  endtask

  task automatic send_frame(input logic [55:0] v);
    int first, stp, len, fcs, fr0, i, gap, sc;
    bit rise;
    logic [15:0] f;
    first = int'(v[55:48]); stp = int'(v[47:40]); len = int'(v[39:32]);
    fcs = int'(v[31:24]); ovh_per = int'(v[23:16]); ocnt = 0;
    for (int j = 0; j < len; j++) exp_b[j] = 8'(first + stp * j);
    exp_n = len;
    if (fcs != 0) begin
      f = ref_crc(len);
      exp_b[len] = f[7:0]; exp_b[len+1] = f[15:8]; exp_n = len + 2;
      if (v[15:0] != 16'h0000) chk(f == v[15:0], "R8", "reference FCS", int'(f), int'(v[15:0]));
    end
    fcs_en_i = (fcs != 0);
    fr0 = fr_cnt; i = 0; gap = 0; sc = 0;
    while (gap < 8) begin
      step_cycle(rise);
      if (rise) begin
        if (i < len) begin
          byte_i = 8'(first + stp * i); msg_i = 1'b1; i++;
          if (scramble) sc = 2;
        end else begin
          msg_i = 1'b0; gap++;
        end
      end else if (sc > 0) begin
        sc--;
        if (sc == 0) byte_i = ~byte_i;  // after the sampling edge
      end
    end
    ovh_per = 0; ovh_i = 1'b0;
    chk(fr_cnt == fr0 + 1, cur_req, "frames decoded", fr_cnt - fr0, 1);
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit rise;
    int rises;
    logic [7:0] b;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1: reset state and first flag on the line
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) chk(bclk_o == 1'b1, "R1", "byte clock after reset", int'(bclk_o), 1);
      chk(ser_o == FLAG_BIT(k), "R1", "idle flag bit", int'(ser_o), int'(FLAG_BIT(k)));
    end
    // R2: byte clock keeps running during idle flags
    @(posedge clk); #1 drv_prev = bclk_o;
    rises = 0;
    for (int c = 0; c < 80; c++) begin step_cycle(rise); rises += int'(rise); end
    chk(rises == 10, "R2", "idle byte clock pulses in 80 cycles", rises, 10);

    for (int n = 0; n < NVEC; n++) begin
      case (n)
        1: cur_req = "R7";
        2, 3: cur_req = "R4";
        4, 7: cur_req = "R9";
        5: cur_req = "R5";
        6: cur_req = "R6";
        default: cur_req = "R8";
      endcase
      scramble = (n == 1);
      saw11 = 1'b0;
      send_frame(VEC[n]);
      if (n == 6) chk(saw11, "R6", "11-cycle interval seen", int'(saw11), 1);
    end
    scramble = 1'b0;

    // R10: bypass sends raw bytes, no stuffing, qualifiers ignored
    bypass_i = 1'b1; byte_i = 8'hFF; msg_i = 1'b0; fcs_en_i = 1'b1;
    repeat (40) @(posedge clk);
    rises = 0;
    for (int c = 0; c < 24; c++) begin @(negedge clk); rises += int'(ser_o); end
    chk(rises == 24, "R10", "ones in 24 bypass bits of 0xFF", rises, 24);
    msg_i = 1'b1; fcs_en_i = 1'b0;
    repeat (20) @(posedge clk);
    rises = 0;
    for (int c = 0; c < 16; c++) begin @(negedge clk); rises += int'(ser_o); end
    chk(rises == 16, "R10", "ones with qualifiers flipped", rises, 16);

    // R11: frame-sync realigns the interval
    b = 8'h35; byte_i = b;
    repeat (27) @(posedge clk);
    per_en = 1'b0;
    @(posedge clk); #1 fsync_i = 1'b1;
    @(posedge clk); #1 fsync_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 0) chk(bclk_o == 1'b1, "R11", "byte clock high after sync", int'(bclk_o), 1);
      if (k == 2) chk(bclk_o == 1'b0, "R11", "byte clock low at third cycle", int'(bclk_o), 0);
      chk(ser_o == b[k], "R11", "realigned bit", int'(ser_o), int'(b[k]));
    end
    @(negedge clk);
    chk(bclk_o == 1'b1, "R11", "next interval starts 8 cycles after sync", int'(bclk_o), 1);
    per_en = 1'b1;
    repeat (40) @(posedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic FLAG_BIT(input int k);
    logic [7:0] f = 8'h7E;
    return f[k];
  endfunction
endmodule